// File: doc/BRIEF.md
# Halfband Interpolate-by-Two Datapath

This block doubles the sample rate of a real 16-bit stream. The halfband filter is split into two polyphase legs. The upper (A) leg is a pure delay with the centre-tap gain applied. The lower (B) leg is a symmetric FIR over the nonzero odd-indexed taps, with mirrored taps pre-added before each multiply. The coefficients are parameters. Every result is rounded half-up and saturated back to 16 bits.

Two output arrangements exist, selected by `mode_int`. This input must be held steady and changed only while reset is asserted.
- **Interleaved (`mode_int` = 1):** a `sync` pulse sets the input phase. A sample is then taken on every other clock, and both legs step at that half rate. The two leg results are merged onto `dout_a` at the full clock rate, and each B result is emitted one clock ahead of the A result that follows it.
- **Split (`mode_int` = 0):** both legs step on every clock. Their results leave on `dout_a` and `dout_b` separately, so the two streams can be merged outside the block.

Top module: `hbi_interp`

## Requirements
- R1: While `rst_n` is low, `dout_a`, `dout_b` and `dout_valid` are all zero.
- R2: In split mode, a sample `x` taken at clock edge t appears on `dout_a` after edge t+9. Its value is `x` scaled by the centre coefficient (Q14 value 16384, i.e. gain 1.0), rounded half-up and saturated.
- R3: In split mode, `dout_b` after edge t+26 carries the lower-leg FIR result for the sample taken at edge t. The result is the sum of coefficient m times the sample m edges older, for m from 0 to 7. The coefficients are symmetric: -150, 900, -2250, 9692, 9692, -2250, 900, -150 (Q14). The sum is rounded half-up at bit 14.
- R4: Any result beyond the 16-bit range is clamped to 32767 or -32768.
- R5: In split mode, `sync` has no effect on the outputs.
- R6: In split mode, `dout_valid` first rises after the 26th edge following the first edge after reset release. It then stays high.
- R7: In interleaved mode, `din` is taken on the edge one clock after the edge where `sync` is high, and on every second edge after that. Values on the other edges are ignored. The same sample feeds both legs.
- R8: In interleaved mode, let d count edges after the `sync` edge, with d ≥ 49. On odd d, `dout_a` holds the B result of sample (d-49)/2. On even d, it holds the A result of sample (d-16)/2. This gives leg latencies of 48 and 15 clocks, with B emitted before A. `dout_b` stays zero in this mode.
- R9: In interleaved mode, `dout_valid` stays low until 48 clocks after the first capture following `sync`, and is high on every clock after that. With no `sync` since reset, it never rises.
- R10: A new `sync` pulse in interleaved mode drops `dout_valid` after that edge. The flag rises again 49 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_int | input | 1 | 1: interleaved single-port output, 0: split A/B ports |
| sync | input | 1 | Input-phase pulse for interleaved mode |
| din | input | 16 | Signed input sample |
| dout_a | output | 16 | Interleaved stream (mode 1) or upper-leg stream (mode 0) |
| dout_b | output | 16 | Lower-leg stream (mode 0), zero in mode 1 |
| dout_valid | output | 1 | High on clocks carrying a filled-pipeline sample |

## Verification
The assertions check the valid flag's own timing on every cycle:
- its rise comes exactly one fill time after `sync` (or after reset in split mode);
- it holds once high;
- it drops after a resync;
- it never rises without a `sync` in interleaved mode;
- `dout_b` is silent in interleaved mode.

Only the bench scenarios can show the numbers. These are the exact leg latencies, the filter and rounding values, saturation, the B-before-A order, that samples on off-phase edges are dropped, and that `sync` has no effect in split mode. The bench compares every output clock against a model of the coefficients.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    // output slot selector for the interleaving register
    typedef enum logic {
        SLOT_A = 1'b0,
        SLOT_B = 1'b1
    } slot_e;

    // round half-up at bit position frac, then clamp to a signed dw-bit range
    function automatic logic signed [63:0] round_sat(input logic signed [63:0] v,
                                                     input int frac, input int dw);
        logic signed [63:0] r;
        logic signed [63:0] hi;
        logic signed [63:0] lo;
        r  = (v + (64'sd1 <<< (frac - 1))) >>> frac;
        hi = (64'sd1 <<< (dw - 1)) - 64'sd1;
        lo = -(64'sd1 <<< (dw - 1));
        if (r > hi)
            r = hi;
        else if (r < lo)
            r = lo;
        return r;
    endfunction

endpackage

// File: rtl/hbi_seq.sv
module hbi_seq #(
    parameter int LAT_B_INT = 48,
    parameter int LAT_B_EXT = 26
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_int,
    input  logic sync,
    output logic ce,
    output logic b_slot,
    output logic valid
);
    localparam int TGT_INT = LAT_B_INT + 1;
    localparam int TGT_EXT = LAT_B_EXT + 1;
    localparam int TGT_MAX = (TGT_INT > TGT_EXT) ? TGT_INT : TGT_EXT;
    localparam int CNTW    = $clog2(TGT_MAX + 1);

    typedef struct packed {
        logic            ph;
        logic            started;
        logic [CNTW-1:0] cnt;
    } seq_t;

    seq_t            st_q, st_d;
    logic [CNTW-1:0] tgt;

    always_comb begin
        tgt  = mode_int ? CNTW'(TGT_INT) : CNTW'(TGT_EXT);
        st_d = st_q;
        if (mode_int && sync) begin
            st_d.ph      = 1'b1;
            st_d.started = 1'b1;
            st_d.cnt     = '0;
        end else begin
            st_d.ph = ~st_q.ph;
            if ((st_q.started || !mode_int) && (st_q.cnt != tgt))
                st_d.cnt = st_q.cnt + 1'b1;
        end
        ce     = mode_int ? (st_q.started & st_q.ph & ~sync) : 1'b1;
        b_slot = mode_int & ce;
        valid  = (st_q.cnt == tgt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/hbi_lower.sv
module hbi_lower #(
    parameter int             DW   = 16,
    parameter int             CW   = 16,
    parameter int             NH   = 4,
    parameter int             FRAC = 14,
    parameter logic [NH*CW-1:0] COEF = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] newest,
    output logic [DW-1:0] y
);
    localparam int NT = 2 * NH;
    localparam int PW = DW + 1;
    localparam int MW = PW + CW;
    localparam int SW = MW + $clog2(NH) + 1;

    typedef struct packed {
        logic [NT-1:0][DW-1:0] tap;
        logic [NH-1:0][PW-1:0] pre;
        logic [NH-1:0][MW-1:0] prod;
        logic [SW-1:0]         acc;
        logic [DW-1:0]         y;
    } low_t;

    low_t               st_q, st_d;
    logic signed [SW-1:0] sum;
    logic signed [63:0]   rs;

    always_comb begin
        st_d = st_q;
        sum  = '0;
        for (int k = 0; k < NH; k++)
            sum = sum + SW'($signed(st_q.prod[k]));
        rs = hbi_pkg::round_sat(64'($signed(st_q.acc)), FRAC, DW);
        if (ce) begin
            st_d.tap[0] = din;
            for (int k = 1; k < NT; k++)
                st_d.tap[k] = st_q.tap[k-1];
            for (int k = 0; k < NH; k++) begin
                // mirrored taps share one coefficient
                st_d.pre[k]  = PW'($signed(st_q.tap[k])) + PW'($signed(st_q.tap[NT-1-k]));
                st_d.prod[k] = MW'($signed(st_q.pre[k])) * MW'($signed(COEF[k*CW +: CW]));
            end
            st_d.acc = sum;
            st_d.y   = rs[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign newest = st_q.tap[0];
    assign y      = st_q.y;

endmodule

// File: rtl/hbi_upper.sv
module hbi_upper #(
    parameter int          DW     = 16,
    parameter int          CW     = 16,
    parameter int          FRAC   = 14,
    parameter logic [CW-1:0] CENTER = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic [DW-1:0] x,
    output logic [DW-1:0] y
);
    localparam int MW = DW + CW;

    typedef struct packed {
        logic [MW-1:0] mul;
        logic [DW-1:0] y;
    } up_t;

    up_t                st_q, st_d;
    logic signed [63:0] rs;

    always_comb begin
        st_d = st_q;
        rs   = hbi_pkg::round_sat(64'($signed(st_q.mul)), FRAC, DW);
        if (ce) begin
            st_d.mul = MW'($signed(x)) * MW'($signed(CENTER));
            st_d.y   = rs[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign y = st_q.y;

endmodule

// File: rtl/hbi_delay.sv
module hbi_delay #(
    parameter int DW      = 16,
    parameter int PAD_INT = 5,
    parameter int PAD_EXT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          mode_int,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int DEPTH = (PAD_INT > PAD_EXT) ? PAD_INT : PAD_EXT;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] ch;
    } dly_t;

    dly_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (ce) begin
            st_d.ch[0] = din;
            for (int k = 1; k < DEPTH; k++)
                st_d.ch[k] = st_q.ch[k-1];
        end
        dout = mode_int ? st_q.ch[PAD_INT-1] : st_q.ch[PAD_EXT-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/hbi_interp.sv
module hbi_interp #(
    parameter int             DW        = 16,
    parameter int             CW        = 16,
    parameter int             NH        = 4,
    parameter int             FRAC      = 14,
    // outermost pair first: -150, 900, -2250, 9692 (Q14)
    parameter logic [NH*CW-1:0] ODD_COEF = {16'h25DC, 16'hF736, 16'h0384, 16'hFF6A},
    parameter logic [CW-1:0]  CENTER    = 16'h4000,
    parameter int             LAT_A_INT = 15,
    parameter int             LAT_B_INT = 48,
    parameter int             LAT_A_EXT = 9,
    parameter int             LAT_B_EXT = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_int,
    input  logic          sync,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout_a,
    output logic [DW-1:0] dout_b,
    output logic          dout_valid
);
    import hbi_pkg::*;

    // register stages inside each leg before the alignment delay
    localparam int RAW_A     = 2;
    localparam int RAW_B     = 4;
    localparam int PAD_A_INT = (LAT_A_INT - 1) / 2 - RAW_A;
    localparam int PAD_B_INT = (LAT_B_INT - 2) / 2 - RAW_B;
    localparam int PAD_A_EXT = LAT_A_EXT - RAW_A;
    localparam int PAD_B_EXT = LAT_B_EXT - RAW_B;

    logic          ce, b_slot, seq_valid;
    logic [DW-1:0] x_new, a_leg, b_leg, a_del, b_del;

    typedef struct packed {
        logic [DW-1:0] mux;
    } out_t;

    out_t  out_q, out_d;
    slot_e sel;

    hbi_seq #(.LAT_B_INT(LAT_B_INT), .LAT_B_EXT(LAT_B_EXT)) u_seq (
        .clk(clk), .rst_n(rst_n), .mode_int(mode_int), .sync(sync),
        .ce(ce), .b_slot(b_slot), .valid(seq_valid)
    );

    hbi_lower #(.DW(DW), .CW(CW), .NH(NH), .FRAC(FRAC), .COEF(ODD_COEF)) u_lower (
        .clk(clk), .rst_n(rst_n), .ce(ce), .din(din), .newest(x_new), .y(b_leg)
    );

    hbi_upper #(.DW(DW), .CW(CW), .FRAC(FRAC), .CENTER(CENTER)) u_upper (
        .clk(clk), .rst_n(rst_n), .ce(ce), .x(x_new), .y(a_leg)
    );

    hbi_delay #(.DW(DW), .PAD_INT(PAD_A_INT), .PAD_EXT(PAD_A_EXT)) u_dly_a (
        .clk(clk), .rst_n(rst_n), .ce(ce), .mode_int(mode_int), .din(a_leg), .dout(a_del)
    );

    hbi_delay #(.DW(DW), .PAD_INT(PAD_B_INT), .PAD_EXT(PAD_B_EXT)) u_dly_b (
        .clk(clk), .rst_n(rst_n), .ce(ce), .mode_int(mode_int), .din(b_leg), .dout(b_del)
    );

    always_comb begin
        sel       = b_slot ? SLOT_B : SLOT_A;
        out_d.mux = (sel == SLOT_B) ? b_del : a_del;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign dout_a     = mode_int ? out_q.mux : a_del;
    assign dout_b     = mode_int ? '0 : b_del;
    assign dout_valid = seq_valid;

endmodule

// File: rtl/hbi_chk.sv
module hbi_chk #(
    parameter int DW        = 16,
    parameter int LAT_B_INT = 48,
    parameter int LAT_B_EXT = 26
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_int,
    input logic          sync,
    input logic [DW-1:0] dout_b,
    input logic          dout_valid
);
    localparam int LIM = ((LAT_B_INT > LAT_B_EXT) ? LAT_B_INT : LAT_B_EXT) + 4;
    localparam int KW  = $clog2(LIM + 1);

    // clocks since the last sync (interleaved) or since reset
    logic [KW-1:0] since;
    logic          seen_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since     <= '0;
            seen_sync <= 1'b0;
        end else if (mode_int && sync) begin
            since     <= '0;
            seen_sync <= 1'b1;
        end else if (since != KW'(LIM)) begin
            since <= since + 1'b1;
        end
    end

    assert_fill_int_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_int && $rose(dout_valid)) |-> (since == KW'(LAT_B_INT + 1)));

    assert_fill_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_int && $rose(dout_valid)) |-> (since == KW'(LAT_B_EXT + 1)));

    assert_no_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_int && !seen_sync) |-> !dout_valid);

    assert_resync_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_int && sync) |=> !dout_valid);

    assert_valid_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && !(mode_int && sync)) |=> dout_valid);

    assert_b_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_int |-> (dout_b == '0));

endmodule

bind hbi_interp hbi_chk #(.DW(DW), .LAT_B_INT(LAT_B_INT), .LAT_B_EXT(LAT_B_EXT)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_int(mode_int), .sync(sync),
    .dout_b(dout_b), .dout_valid(dout_valid)
);

// File: tb/tb_hbi_interp.sv
module tb_hbi_interp;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               mode_int = 1'b0;
    logic               sync = 1'b0;
    logic signed [15:0] din = '0;
    logic signed [15:0] dout_a, dout_b;
    logic               dout_valid;

    int n_chk = 0;
    int n_bad = 0;
    int xs[64];
    int ns = 0;
    localparam int G[8] = '{-150, 900, -2250, 9692, 9692, -2250, 900, -150};

    always #2 clk = ~clk;

    hbi_interp dut (
        .clk(clk), .rst_n(rst_n), .mode_int(mode_int), .sync(sync), .din(din),
        .dout_a(dout_a), .dout_b(dout_b), .dout_valid(dout_valid)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic longint rs(input longint v);
        longint r;
        r = (v + 8192) >>> 14;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    function automatic int x_at(input int n);
        if (n < 0 || n >= ns) return 0;
        return xs[n];
    endfunction

    function automatic longint ya(input int n);
        return rs(longint'(x_at(n)) * 16384);
    endfunction

    function automatic longint yb(input int n);
        longint s = 0;
        for (int m = 0; m < 8; m++) s += longint'(G[m]) * x_at(n - m);
        return rs(s);
    endfunction

    task automatic set_stim(input int kind);
        int p[8] = '{-1, 1, -1, 1, 1, -1, 1, -1};
        for (int i = 0; i < 64; i++) xs[i] = 0;
        if (kind == 0) begin
            ns = 8; xs[3] = 12000;
        end else if (kind == 1) begin
            ns = 30;
            for (int i = 0; i < 30; i++) xs[i] = ((i * 7919 + 123) % 20001) - 10000;
        end else begin
            ns = 20;
            for (int i = 0; i < 8; i++) begin
                xs[i]     = p[i] * 32767;
                xs[i + 10] = -p[i] * 32767;
            end
        end
    endtask

    task automatic do_reset(input logic md);
        rst_n = 1'b0; mode_int = md; sync = 1'b0; din = 16'sh1234;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 dout_a in reset", dout_a, 0);
        chk("R1 dout_b in reset", dout_b, 0);
        chk("R1 valid in reset", dout_valid, 0);
        rst_n = 1'b1;
    endtask

    // split mode: one sample per edge, edge j after reset release
    task automatic run_ext(input int kind, input bit with_sync);
        string ta, tb2;
        set_stim(kind);
        do_reset(1'b0);
        ta  = (kind == 2) ? "R4 dout_a" : (with_sync ? "R5 dout_a" : "R2 dout_a");
        tb2 = (kind == 2) ? "R4 dout_b" : (with_sync ? "R5 dout_b" : "R3 dout_b");
        for (int j = 0; j < 26 + ns + 10; j++) begin
            din  = 16'(x_at(j));
            sync = with_sync && (j % 5 == 2);
            @(posedge clk);
            @(negedge clk);
            chk(ta, dout_a, ya(j - 9));
            chk(tb2, dout_b, yb(j - 26));
            chk("R6 valid split", dout_valid, (j >= 26) ? 1 : 0);
        end
        sync = 1'b0;
    endtask

    // interleaved mode with odd-edge junk, then a resync
    task automatic run_int();
        set_stim(1);
        do_reset(1'b1);
        for (int j = 0; j < 60; j++) begin
            din = 16'sh5A5A;
            @(posedge clk);
            @(negedge clk);
            chk("R9 valid before sync", dout_valid, 0);
            chk("R8 dout_b quiet", dout_b, 0);
        end
        for (int d = 0; d < 49 + 2 * ns + 12; d++) begin
            sync = (d == 0);
            // R7: only edges d = 1, 3, 5, ... take a sample
            din = (d >= 1 && ((d - 1) % 2 == 0)) ? 16'(x_at((d - 1) / 2)) : 16'sh5A5A;
            @(posedge clk);
            @(negedge clk);
            chk("R9 valid fill", dout_valid, (d >= 49) ? 1 : 0);
            chk("R8 dout_b quiet", dout_b, 0);
            if (d >= 49) begin
                if (d % 2 == 1) chk("R8 B slot (R7 capture)", dout_a, yb((d - 49) / 2));
                else            chk("R8 A slot (R7 capture)", dout_a, ya((d - 16) / 2));
            end
        end
        for (int d = 0; d < 56; d++) begin
            sync = (d == 0);
            din  = 16'sh0000;
            @(posedge clk);
            @(negedge clk);
            chk("R10 valid after resync", dout_valid, (d >= 49) ? 1 : 0);
        end
        sync = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1..all actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        run_ext(0, 1'b0);
        run_ext(1, 1'b0);
        run_ext(1, 1'b1);
        run_ext(2, 1'b0);
        run_int();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule